// File: doc/BRIEF.md
# Isochronous Cycle Timer

This block keeps the 32-bit time-of-day value used to pace an isochronous serial bus. Three fields form a cascade. A 12-bit offset field counts 24.576 MHz ticks modulo 3072, so one wrap is one 125 µs cycle. A 13-bit cycle field counts offset wraps modulo 8000. A 7-bit seconds field counts cycle wraps modulo 128. The fast tick arrives as a clock enable on the system clock.

When the node is cycle master, the counter runs freely and its current value is presented on `timeOut`, ready for a cycle start message. When the node is not master, each received cycle start loads its data field into the counter. If no cycle start arrives, the counter keeps running so the local time base is held. An external 8 kHz tick can be selected to set cycle boundaries: each tick clears the offset and advances the cycle field. Software can write the whole value at any time. A one-clock `cycleTick` pulse marks every cycle boundary the counter reaches by counting.

Top module: `iso_cycle_timer`

## Requirements
- R1: After reset, `timeOut` is 0 and `cycleTick` is 0.
- R2: With `countEnable` high and internal timing selected (`extClkSel` low), each clock with `tickEn` high raises the offset field `timeOut[11:0]` by one. Without `tickEn`, the value holds.
- R3: When the offset is 3071 and a tick arrives, the offset returns to 0, the cycle field `timeOut[24:12]` advances by one, and `cycleTick` is high for exactly the one clock in which the new value is shown.
- R4: When the cycle field is 7999 and the offset wraps, the cycle field returns to 0 and the seconds field `timeOut[31:25]` advances by one. The seconds field wraps from 127 to 0.
- R5: `timeOut` always shows the present counter value, laid out as seconds in [31:25], cycle in [24:12] and offset in [11:0], whether or not the node is master.
- R6: When `isMaster` is low, `rxCsValid` loads `rxCsData` into the counter, visible on the next clock, with no `cycleTick`. When `isMaster` is high, `rxCsValid` has no effect.
- R7: `swWrEn` loads `swWrData`, visible on the next clock. In the same clock it takes priority over a received cycle start.
- R8: A load of either kind takes priority over an increment, a wrap or an external tick in the same clock, and that clock produces no `cycleTick`.
- R9: With `extClkSel` high, `extTick` clears the offset, advances the cycle field as a wrap would (including the carry into seconds), and pulses `cycleTick`. In this mode the offset never wraps by itself: it stops at 3071.
- R10: With `countEnable` low, neither `tickEn` nor `extTick` changes the value, but both loads still work.
- R11: An offset field loaded above 3071 wraps to 0 on the next tick. A cycle field loaded above 7999 returns to 0 on the next wrap and carries into seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | 24.576 MHz count enable, one clock wide |
| countEnable | input | 1 | Allows the counter to advance |
| isMaster | input | 1 | Node is cycle master |
| extClkSel | input | 1 | External 8 kHz tick sets cycle boundaries |
| extTick | input | 1 | External 8 kHz tick, one clock wide |
| rxCsValid | input | 1 | A cycle start was received |
| rxCsData | input | 32 | Time field of the received cycle start |
| swWrEn | input | 1 | Software write strobe |
| swWrData | input | 32 | Software write value |
| timeOut | output | 32 | Current counter value |
| cycleTick | output | 1 | One-clock pulse at a counted cycle boundary |

## Verification
Every result, whether an increment, a wrap, a load or a `cycleTick` pulse, appears exactly one clock after the edge that samples the stimulus, because the counter and the pulse are registered together. The bench drives inputs on the falling edge. Its reference model updates on the rising edge from those inputs, and both outputs are compared a short delay after every rising edge. Directed checks on the falling edge confirm the wrap, carry, priority and external-tick values one clock after each stimulus clock.

// File: rtl/iso_ct_pkg.sv
package iso_ct_pkg;
  // strobes from control to datapath for one clock
  typedef struct packed {
    logic loadSw;      // take software value
    logic loadRx;      // take received cycle-start value
    logic stepOffset;  // offset + 1
    logic rollOffset;  // offset -> 0, carry into cycle field
  } ctStrobes_t;
endpackage

// File: rtl/iso_ct_ctrl.sv
module iso_ct_ctrl
  import iso_ct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       countEnable,
  input  logic       isMaster,
  input  logic       extClkSel,
  input  logic       extTick,
  input  logic       rxCsValid,
  input  logic       swWrEn,
  input  logic       offsetAtEnd,
  output ctStrobes_t stb
);
  logic internalRoll;
  logic externalRoll;

  assign internalRoll = !extClkSel && tickEn && offsetAtEnd;
  assign externalRoll = extClkSel && extTick;

  always_comb begin
    stb            = '0;
    stb.loadSw     = swWrEn;
    stb.loadRx     = rxCsValid && !isMaster && !swWrEn;
    stb.rollOffset = countEnable && (internalRoll || externalRoll);
    stb.stepOffset = countEnable && tickEn && !offsetAtEnd;
  end

  // R6: a master never takes a received cycle start
  p_master_ignores_rx_r6: assert property (@(posedge clk) disable iff (!rstN)
    isMaster |-> !stb.loadRx);
  // R7: at most one load source per clock
  p_single_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.loadSw && stb.loadRx));
  // R10: no advance while counting is disabled
  p_hold_when_disabled_r10: assert property (@(posedge clk) disable iff (!rstN)
    !countEnable |-> !(stb.stepOffset || stb.rollOffset));
endmodule

// File: rtl/iso_ct_datapath.sv
module iso_ct_datapath
  import iso_ct_pkg::*;
#(
  parameter int OFFSET_W   = 12,
  parameter int OFFSET_MOD = 3072,
  parameter int COUNT_W    = 13,
  parameter int COUNT_MOD  = 8000,
  parameter int SEC_W      = 7,
  localparam int TIME_W    = OFFSET_W + COUNT_W + SEC_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctStrobes_t        stb,
  input  logic [TIME_W-1:0] swWrData,
  input  logic [TIME_W-1:0] rxCsData,
  output logic [TIME_W-1:0] timeOut,
  output logic              cycleTick,
  output logic              offsetAtEnd
);
  localparam logic [OFFSET_W-1:0] OFFSET_LAST = OFFSET_W'(OFFSET_MOD - 1);
  localparam logic [COUNT_W-1:0]  COUNT_LAST  = COUNT_W'(COUNT_MOD - 1);

  logic [OFFSET_W-1:0] offsetQ;
  logic [COUNT_W-1:0]  countQ;
  logic [SEC_W-1:0]    secQ;
  logic                countAtEnd;
  logic                anyLoad;
  logic [TIME_W-1:0]   loadValue;

  assign offsetAtEnd = offsetQ >= OFFSET_LAST;
  assign countAtEnd  = countQ >= COUNT_LAST;
  assign anyLoad     = stb.loadSw || stb.loadRx;
  assign loadValue   = stb.loadSw ? swWrData : rxCsData;
  assign timeOut     = {secQ, countQ, offsetQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetQ   <= '0;
      countQ    <= '0;
      secQ      <= '0;
      cycleTick <= 1'b0;
    end else begin
      cycleTick <= 1'b0;
      if (anyLoad) begin
        {secQ, countQ, offsetQ} <= loadValue;
      end else if (stb.rollOffset) begin
        offsetQ   <= '0;
        cycleTick <= 1'b1;
        if (countAtEnd) begin
          countQ <= '0;
          secQ   <= secQ + 1'b1;
        end else begin
          countQ <= countQ + 1'b1;
        end
      end else if (stb.stepOffset) begin
        offsetQ <= offsetQ + 1'b1;
      end
    end
  end

  // R7: a software write shows on the next clock
  p_sw_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadSw |=> timeOut == $past(swWrData));
  // R6: a received cycle start shows on the next clock
  p_rx_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadRx |=> timeOut == $past(rxCsData));
  // R2: a plain step raises only the offset
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepOffset && !stb.rollOffset && !anyLoad)
      |=> (offsetQ == OFFSET_W'($past(offsetQ) + 1'b1)) && $stable(countQ) && $stable(secQ));
  // R3: a boundary pulse always shows a cleared offset
  p_tick_at_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    cycleTick |-> offsetQ == '0);
  // R8: a load clock never yields a boundary pulse
  p_load_no_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    anyLoad |=> !cycleTick);
endmodule

// File: rtl/iso_cycle_timer.sv
module iso_cycle_timer
  import iso_ct_pkg::*;
#(
  parameter int OFFSET_W   = 12,
  parameter int OFFSET_MOD = 3072,
  parameter int COUNT_W    = 13,
  parameter int COUNT_MOD  = 8000,
  parameter int SEC_W      = 7,
  localparam int TIME_W    = OFFSET_W + COUNT_W + SEC_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              countEnable,
  input  logic              isMaster,
  input  logic              extClkSel,
  input  logic              extTick,
  input  logic              rxCsValid,
  input  logic [TIME_W-1:0] rxCsData,
  input  logic              swWrEn,
  input  logic [TIME_W-1:0] swWrData,
  output logic [TIME_W-1:0] timeOut,
  output logic              cycleTick
);
  ctStrobes_t stb;
  logic       offsetAtEnd;

  iso_ct_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .countEnable(countEnable),
    .isMaster(isMaster), .extClkSel(extClkSel), .extTick(extTick),
    .rxCsValid(rxCsValid), .swWrEn(swWrEn), .offsetAtEnd(offsetAtEnd), .stb(stb)
  );

  iso_ct_datapath #(
    .OFFSET_W(OFFSET_W), .OFFSET_MOD(OFFSET_MOD), .COUNT_W(COUNT_W),
    .COUNT_MOD(COUNT_MOD), .SEC_W(SEC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .swWrData(swWrData), .rxCsData(rxCsData),
    .timeOut(timeOut), .cycleTick(cycleTick), .offsetAtEnd(offsetAtEnd)
  );
endmodule

// File: tb/iso_cycle_timer_tb.sv
module iso_cycle_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic tickEn = 0, countEnable = 0, isMaster = 0, extClkSel = 0, extTick = 0;
  logic rxCsValid = 0, swWrEn = 0;
  logic [31:0] rxCsData = 0, swWrData = 0;
  logic [31:0] timeOut;
  logic cycleTick;

  int checks = 0, failures = 0;
  string curReq = "R1";

  // behavioural reference state
  int mSec = 0, mCnt = 0, mOff = 0;
  bit mTick = 0;

  iso_cycle_timer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .countEnable(countEnable),
    .isMaster(isMaster), .extClkSel(extClkSel), .extTick(extTick),
    .rxCsValid(rxCsValid), .rxCsData(rxCsData), .swWrEn(swWrEn),
    .swWrData(swWrData), .timeOut(timeOut), .cycleTick(cycleTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] packTime(int s, int c, int o);
    return {s[6:0], c[12:0], o[11:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: advance on each rising edge, compare shortly after
  always @(posedge clk) begin
    if (!rstN) begin
      mSec = 0; mCnt = 0; mOff = 0; mTick = 0;
    end else begin
      mTick = 0;
      if (swWrEn) begin
        mSec = swWrData[31:25]; mCnt = swWrData[24:12]; mOff = swWrData[11:0];
      end else if (rxCsValid && !isMaster) begin
        mSec = rxCsData[31:25]; mCnt = rxCsData[24:12]; mOff = rxCsData[11:0];
      end else if (countEnable) begin
        if ((extClkSel && extTick) || (!extClkSel && tickEn && mOff >= 3071)) begin
          mOff = 0; mTick = 1;
          if (mCnt >= 7999) begin mCnt = 0; mSec = (mSec + 1) % 128; end
          else mCnt = mCnt + 1;
        end else if (tickEn && mOff < 3071) begin
          mOff = mOff + 1;
        end
      end
    end
    #2;
    check({curReq, " model"}, timeOut, packTime(mSec, mCnt, mOff));
    check({curReq, " model tick"}, {31'd0, cycleTick}, {31'd0, mTick});
  end

  // one clock with the given pulse inputs, then drop them
  task automatic cyc(bit te = 0, bit et = 0, bit rv = 0, bit sw = 0);
    tickEn = te; extTick = et; rxCsValid = rv; swWrEn = sw;
    @(negedge clk);
    tickEn = 0; extTick = 0; rxCsValid = 0; swWrEn = 0;
  endtask

  task automatic swWrite(logic [31:0] v);
    swWrData = v; cyc(0, 0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    check("R1 reset value", timeOut, 32'd0);
    check("R1 reset tick", {31'd0, cycleTick}, 32'd0);
    rstN = 1;
    @(negedge clk);

    // R2: counting follows the enable pattern
    curReq = "R2"; countEnable = 1;
    for (int i = 0; i < 20; i++) cyc(i % 3 != 0);
    check("R2 offset after 13 ticks", timeOut, packTime(0, 0, 13));

    // R3: offset wrap with carry and pulse
    curReq = "R3";
    swWrite(packTime(0, 5, 3070));
    cyc(1);
    check("R3 at last offset", timeOut, packTime(0, 5, 3071));
    cyc(1);
    check("R3 wrapped", timeOut, packTime(0, 6, 0));
    check("R3 tick high", {31'd0, cycleTick}, 32'd1);
    cyc(0);
    check("R3 tick one clock", {31'd0, cycleTick}, 32'd0);

    // R4/R5: full cascade and seconds wrap, as master
    curReq = "R4"; isMaster = 1;
    swWrite(packTime(127, 7999, 3071));
    cyc(1);
    check("R4 seconds wrap", timeOut, packTime(0, 0, 0));
    swWrite(packTime(9, 7999, 3071));
    cyc(1);
    check("R5 field layout", timeOut, {7'd10, 13'd0, 12'd0});

    // R6: master ignores, non-master loads
    curReq = "R6";
    rxCsData = packTime(33, 1234, 777);
    cyc(0, 0, 1);
    check("R6 master ignores rx", timeOut, {7'd10, 13'd0, 12'd0});
    isMaster = 0;
    cyc(1, 0, 1);
    check("R6 rx load", timeOut, packTime(33, 1234, 777));
    check("R6 no tick on load", {31'd0, cycleTick}, 32'd0);
    for (int i = 0; i < 5; i++) cyc(1);
    check("R6 runs on after load", timeOut, packTime(33, 1234, 782));

    // R7: software beats received cycle start
    curReq = "R7";
    swWrData = packTime(1, 2, 3); rxCsData = packTime(4, 5, 6);
    cyc(1, 0, 1, 1);
    check("R7 sw priority", timeOut, packTime(1, 2, 3));

    // R8: load beats a wrap in the same clock
    curReq = "R8";
    swWrite(packTime(0, 0, 3071));
    rxCsData = packTime(2, 2, 2);
    cyc(1, 0, 1);
    check("R8 load over wrap", timeOut, packTime(2, 2, 2));
    check("R8 no tick", {31'd0, cycleTick}, 32'd0);

    // R9: external tick mode
    curReq = "R9"; extClkSel = 1;
    swWrite(packTime(0, 7999, 3069));
    for (int i = 0; i < 4; i++) cyc(1);
    check("R9 offset stops at end", timeOut, packTime(0, 7999, 3071));
    cyc(0, 1);
    check("R9 ext tick clears", timeOut, packTime(1, 0, 0));
    check("R9 ext tick pulse", {31'd0, cycleTick}, 32'd1);
    for (int i = 0; i < 7; i++) cyc(1);
    cyc(1, 1);
    check("R9 mid-cycle ext tick", timeOut, packTime(1, 1, 0));
    extClkSel = 0;

    // R10: disabled counting
    curReq = "R10"; countEnable = 0;
    swWrite(packTime(3, 3, 3071));
    cyc(1); cyc(0, 1); cyc(1);
    check("R10 holds", timeOut, packTime(3, 3, 3071));
    check("R10 no tick", {31'd0, cycleTick}, 32'd0);
    swWrite(packTime(4, 4, 4));
    check("R10 load still works", timeOut, packTime(4, 4, 4));
    countEnable = 1;

    // R11: out-of-range fields
    curReq = "R11";
    swWrite(packTime(5, 100, 4095));
    cyc(1);
    check("R11 offset over range", timeOut, packTime(5, 101, 0));
    swWrite(packTime(5, 8191, 3071));
    cyc(1);
    check("R11 count over range", timeOut, packTime(6, 0, 0));

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule